// File: doc/BRIEF.md
# Reconfigurable Lookup Logic Element Array

This block is a row of coarse-grained logic elements that together form one datapath word. A controlling state machine picks the operation of the whole row in every cycle. Each element looks up a multibit result from a fixed function table indexed by a 3-bit function code. The available operations are add, subtract, equality compare, bitwise AND/OR/XOR and pass-through. The elements are chained through their carries, so the row behaves as one wide adder, subtractor or comparator.

Each element has two registers: a result slice and its carry. The registers can capture the current compute output. They can drive the row's outputs in place of the live values. They can also replace the first operand on the next cycle, which lets an accumulation or a compare against the previous result run with no external path.

The function changes in the cycle the code changes. A result captured under one function can be the operand of a different function on the very next cycle.

Top module: `lut_le_array`

## Requirements
- R1: While reset is asserted and after its release, both registers of every element hold zero. With the register view selected, `result` and `carryOut` read all zeros until the first capture.
- R2: Function code 000 (add) gives `result` = A + B + c0, modulo 2^W. c0 is `carryIn` when `cfgCarryEn` is 1 and 0 otherwise. `carryOut[i]` is the carry out of the low (i+1)*SLICE_W bits of that sum.
- R3: Function code 001 (subtract) gives `result` = A + ~B + c0. c0 is `carryIn` when `cfgCarryEn` is 1 and 1 otherwise. With c0 = 1 this is A − B, and `carryOut[i]` is 1 when the low (i+1)*SLICE_W bits produce no borrow.
- R4: Function code 010 (compare) drives `result` bit 0 with c0 AND (A == B) and every other result bit with 0. c0 is `carryIn` when `cfgCarryEn` is 1 and 1 otherwise. `carryOut[i]` is c0 AND (the low (i+1)*SLICE_W bits of A and B are equal).
- R5: Function codes 011, 100 and 101 give A AND B, A OR B and A XOR B, with every `carryOut` bit 0.
- R6: Function code 111 passes A to `result`. Code 110 drives `result` with zero. Both drive every `carryOut` bit 0.
- R7: `cascadeOut[i]` is element i's live carry when `cfgCascSel` is 1. Otherwise it is the top bit of element i's live compute slice.
- R8: On a clock edge with `cfgRegEn` high, every element stores its live compute slice and live carry. With `cfgRegEn` low, both registers keep their values.
- R9: With `cfgUseReg` high, `result` and `carryOut` show the stored registers instead of the live values.
- R10: With `cfgFeedback` high, each element takes its stored result slice as its A operand in place of the external operand A.
- R11: A new function code takes effect in the same cycle it is applied. A value stored under one function is the operand of a different function in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgFunc | input | 3 | Function code for the whole row |
| cfgCascSel | input | 1 | Cascade output takes carry (1) or compute slice top bit (0) |
| cfgUseReg | input | 1 | Outputs show stored registers (1) or live values (0) |
| cfgFeedback | input | 1 | A operand taken from stored result slices |
| cfgCarryEn | input | 1 | Element 0 takes its carry from `carryIn` |
| cfgRegEn | input | 1 | Capture live values into the registers at the clock edge |
| opA | input | NUM_LE*SLICE_W | Operand A |
| opB | input | NUM_LE*SLICE_W | Operand B |
| carryIn | input | 1 | External carry into element 0 |
| result | output | NUM_LE*SLICE_W | Result word |
| carryOut | output | NUM_LE | Per-element carry |
| cascadeOut | output | NUM_LE | Per-element cascade output |

## Verification
The bench builds the row with 16 one-bit elements, so the word is 16 bits and every bit position owns a carry and cascade tap. This puts every intermediate carry of the ripple chain in view, bit by bit, for add, subtract and the equality chain. The operand pairs are chosen to make carries ripple through the whole word, to produce a borrow, and to cause a mismatch only in bit 0. A sequence of capture, hold, feedback and function switches then exercises the registered path.

// File: rtl/lea_pkg.sv
package lea_pkg;

  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_SUB  = 3'b001,
    FN_CMP  = 3'b010,
    FN_AND  = 3'b011,
    FN_OR   = 3'b100,
    FN_XOR  = 3'b101,
    FN_NONE = 3'b110,
    FN_PASS = 3'b111
  } leFunc_e;

  typedef struct packed {
    leFunc_e func;
    logic    cin0;
    logic    useReg;
    logic    feedback;
    logic    capture;
    logic    cascCarry;
  } leStrobes_t;

endpackage

// File: rtl/lea_ctrl.sv
module lea_ctrl
  import lea_pkg::*;
(
  input  logic [2:0]  cfgFunc,
  input  logic        cfgCascSel,
  input  logic        cfgUseReg,
  input  logic        cfgFeedback,
  input  logic        cfgCarryEn,
  input  logic        cfgRegEn,
  input  logic        carryIn,
  output leStrobes_t  strobes
);

  leFunc_e funcDec;
  logic    defaultCin;

  assign funcDec = leFunc_e'(cfgFunc);

  // Subtract needs +1 for two's complement; compare starts its chain at "equal".
  always_comb begin
    unique case (funcDec)
      FN_SUB, FN_CMP: defaultCin = 1'b1;
      default:        defaultCin = 1'b0;
    endcase
  end

  always_comb begin
    strobes.func      = funcDec;
    strobes.cin0      = cfgCarryEn ? carryIn : defaultCin;
    strobes.useReg    = cfgUseReg;
    strobes.feedback  = cfgFeedback;
    strobes.capture   = cfgRegEn;
    strobes.cascCarry = cfgCascSel;
  end

endmodule

// File: rtl/lea_lut_slice.sv
module lea_lut_slice
  import lea_pkg::*;
#(
  parameter int SLICE_W = 1
) (
  input  leFunc_e             func,
  input  logic [SLICE_W-1:0]  a,
  input  logic [SLICE_W-1:0]  b,
  input  logic                cin,
  output logic [SLICE_W-1:0]  y,
  output logic                cout
);

  logic [SLICE_W:0] sumAdd;
  logic [SLICE_W:0] sumSub;

  assign sumAdd = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
  assign sumSub = {1'b0, a} + {1'b0, ~b} + {{SLICE_W{1'b0}}, cin};

  // Fixed function table: one entry per code.
  always_comb begin
    y    = '0;
    cout = 1'b0;
    unique case (func)
      FN_ADD:  {cout, y} = sumAdd;
      FN_SUB:  {cout, y} = sumSub;
      FN_CMP:  cout = cin & (a == b);
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_PASS: y = a;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/lea_datapath.sv
module lea_datapath
  import lea_pkg::*;
#(
  parameter int NUM_LE  = 16,
  parameter int SLICE_W = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  leStrobes_t                   strobes,
  input  logic [NUM_LE*SLICE_W-1:0]    opA,
  input  logic [NUM_LE*SLICE_W-1:0]    opB,
  output logic [NUM_LE*SLICE_W-1:0]    result,
  output logic [NUM_LE-1:0]            carryOut,
  output logic [NUM_LE-1:0]            cascadeOut
);

  localparam int W = NUM_LE * SLICE_W;

  logic [NUM_LE-1:0][SLICE_W-1:0] sliceReg;
  logic [NUM_LE-1:0]              carryReg;
  logic [NUM_LE-1:0][SLICE_W-1:0] computeSlice;
  logic [NUM_LE-1:0][SLICE_W-1:0] lutY;
  logic [NUM_LE-1:0]              chain;
  logic [NUM_LE-1:0]              chainIn;

  for (genvar i = 0; i < NUM_LE; i++) begin : g_le
    logic [SLICE_W-1:0] aSel;

    if (i == 0) begin : g_head
      assign chainIn[i] = strobes.cin0;
    end else begin : g_link
      assign chainIn[i] = chain[i-1];
    end

    assign aSel = strobes.feedback ? sliceReg[i] : opA[i*SLICE_W +: SLICE_W];

    lea_lut_slice #(.SLICE_W(SLICE_W)) i_lut (
      .func (strobes.func),
      .a    (aSel),
      .b    (opB[i*SLICE_W +: SLICE_W]),
      .cin  (chainIn[i]),
      .y    (lutY[i]),
      .cout (chain[i])
    );

    // Element 0 carries the full-word equality in compare mode.
    if (i == 0) begin : g_cmpTap
      assign computeSlice[i] = (strobes.func == FN_CMP) ?
                               SLICE_W'(chain[NUM_LE-1]) : lutY[i];
    end else begin : g_plain
      assign computeSlice[i] = lutY[i];
    end

    assign result[i*SLICE_W +: SLICE_W] = strobes.useReg ? sliceReg[i] : computeSlice[i];
    assign carryOut[i]   = strobes.useReg ? carryReg[i] : chain[i];
    assign cascadeOut[i] = strobes.cascCarry ? chain[i] : computeSlice[i][SLICE_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sliceReg <= '0;
      carryReg <= '0;
    end else if (strobes.capture) begin
      sliceReg <= computeSlice;
      carryReg <= chain;
    end
  end

  AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(sliceReg) && $stable(carryReg))); // R8

  AST_CAPTURE_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (sliceReg == $past(computeSlice))); // R8

  AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.func == FN_CMP) |-> (computeSlice[W/SLICE_W-1:0] >> 1) == '0); // R4

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.func inside {FN_AND, FN_OR, FN_XOR, FN_NONE, FN_PASS}) |-> chain == '0); // R5

endmodule

// File: rtl/lut_le_array.sv
module lut_le_array
  import lea_pkg::*;
#(
  parameter int NUM_LE  = 16,
  parameter int SLICE_W = 1,
  localparam int W = NUM_LE * SLICE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    cfgFunc,
  input  logic          cfgCascSel,
  input  logic          cfgUseReg,
  input  logic          cfgFeedback,
  input  logic          cfgCarryEn,
  input  logic          cfgRegEn,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          carryIn,
  output logic [W-1:0]  result,
  output logic [NUM_LE-1:0] carryOut,
  output logic [NUM_LE-1:0] cascadeOut
);

  leStrobes_t strobes;

  lea_ctrl i_ctrl (
    .cfgFunc     (cfgFunc),
    .cfgCascSel  (cfgCascSel),
    .cfgUseReg   (cfgUseReg),
    .cfgFeedback (cfgFeedback),
    .cfgCarryEn  (cfgCarryEn),
    .cfgRegEn    (cfgRegEn),
    .carryIn     (carryIn),
    .strobes     (strobes)
  );

  lea_datapath #(.NUM_LE(NUM_LE), .SLICE_W(SLICE_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .carryOut   (carryOut),
    .cascadeOut (cascadeOut)
  );

  AST_REG_VIEW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgUseReg && $past(cfgUseReg) && !$past(cfgRegEn)) |->
      ($stable(result) && $stable(carryOut))); // R9

endmodule

// File: tb/test_lut_le_array.sv
`timescale 1ns/1ps
module test_lut_le_array;

  localparam int NUM_LE  = 16;
  localparam int SLICE_W = 1;
  localparam int W = NUM_LE * SLICE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cfgFunc = 3'b000;
  logic cfgCascSel = 1'b0, cfgUseReg = 1'b0, cfgFeedback = 1'b0;
  logic cfgCarryEn = 1'b0, cfgRegEn = 1'b0, carryIn = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [W-1:0] result;
  logic [NUM_LE-1:0] carryOut, cascadeOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  lut_le_array #(.NUM_LE(NUM_LE), .SLICE_W(SLICE_W)) i_lut_le_array (
    .clk(clk), .rstN(rstN), .cfgFunc(cfgFunc), .cfgCascSel(cfgCascSel),
    .cfgUseReg(cfgUseReg), .cfgFeedback(cfgFeedback), .cfgCarryEn(cfgCarryEn),
    .cfgRegEn(cfgRegEn), .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .cascadeOut(cascadeOut)
  );

  // {func, carryEn, carryIn, cascSel, A, B}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h4321},  // R2
    {3'd0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h0001},  // R2 R7 full ripple
    {3'd0, 1'b1, 1'b1, 1'b1, 16'h00FF, 16'h0000},  // R2 external carry
    {3'd1, 1'b0, 1'b0, 1'b0, 16'h5000, 16'h1234},  // R3
    {3'd1, 1'b0, 1'b0, 1'b1, 16'h0003, 16'h0005},  // R3 borrow
    {3'd1, 1'b1, 1'b0, 1'b1, 16'h0010, 16'h0001},  // R3 carry-in 0
    {3'd2, 1'b0, 1'b0, 1'b1, 16'hABCD, 16'hABCD},  // R4 equal
    {3'd2, 1'b0, 1'b0, 1'b1, 16'hABCD, 16'hABCC},  // R4 differs in bit 0
    {3'd2, 1'b1, 1'b0, 1'b0, 16'h7777, 16'h7777},  // R4 chain forced false
    {3'd3, 1'b0, 1'b0, 1'b1, 16'hF0F0, 16'hFF00},  // R5 AND
    {3'd4, 1'b0, 1'b0, 1'b0, 16'hF0F0, 16'h0F01},  // R5 OR
    {3'd5, 1'b0, 1'b0, 1'b1, 16'hAAAA, 16'hFFFF},  // R5 XOR
    {3'd7, 1'b0, 1'b0, 1'b0, 16'h1357, 16'hFFFF},  // R6 pass
    {3'd6, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF}   // R6 zero code
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the live outputs for a one-bit-slice row.
  task automatic model(input logic [2:0] f, input logic cen, input logic ci,
                       input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] res, output logic [15:0] cy);
    logic c0;
    logic [15:0] bb;
    c0 = cen ? ci : (f == 3'd1 || f == 3'd2);
    bb = (f == 3'd1) ? ~b : b;
    res = '0;
    cy = '0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] m;
      logic [31:0] s;
      m = (32'd1 << (i + 1)) - 32'd1;
      s = ({16'd0, a} & m) + ({16'd0, bb} & m) + {31'd0, c0};
      if (f <= 3'd1) cy[i] = s[i+1];
      if (f == 3'd2) cy[i] = c0 && (({16'd0, a} & m) == ({16'd0, b} & m));
    end
    case (f)
      3'd0: res = a + b + {15'd0, c0};
      3'd1: res = a + ~b + {15'd0, c0};
      3'd2: res = {15'd0, cy[15]};
      3'd3: res = a & b;
      3'd4: res = a | b;
      3'd5: res = a ^ b;
      3'd7: res = a;
      default: res = '0;
    endcase
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] eRes, eCy;
    // R1: register view during and after reset
    cfgUseReg = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 result in reset", 32'(result), 32'h0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    #1 chk("R1 result after reset", 32'(result), 32'h0);
    chk("R1 carry after reset", 32'(carryOut), 32'h0);

    // Table walk over live outputs
    cfgUseReg = 1'b0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {cfgFunc, cfgCarryEn, carryIn, cfgCascSel, opA, opB} = VEC[v];
      #1;
      model(cfgFunc, cfgCarryEn, carryIn, opA, opB, eRes, eCy);
      chk("R2-R6 table result", 32'(result), 32'(eRes));
      chk("R2-R6 table carry", 32'(carryOut), 32'(eCy));
      chk("R7 table cascade", 32'(cascadeOut), cfgCascSel ? 32'(eCy) : 32'(eRes));
    end

    // R8: capture 5+3
    @(negedge clk);
    cfgFunc = 3'd0; cfgCarryEn = 1'b0; cfgCascSel = 1'b0;
    opA = 16'h0005; opB = 16'h0003; cfgRegEn = 1'b1;
    @(negedge clk);
    cfgRegEn = 1'b0; opA = 16'h0F00; cfgUseReg = 1'b1;
    #1 chk("R9 stored sum shown", 32'(result), 32'h8);
    chk("R8 R9 stored carry", 32'(carryOut), 32'h0007);
    chk("R7 cascade stays live", 32'(cascadeOut), 32'h0F03);
    @(negedge clk);
    #1 chk("R8 hold with enable low", 32'(result), 32'h8);

    // R10: feedback add, stored 8 + 0x10 = 0x18
    cfgUseReg = 1'b0; cfgFeedback = 1'b1; opB = 16'h0010; cfgRegEn = 1'b1;
    #1 chk("R10 feedback add live", 32'(result), 32'h18);
    @(negedge clk);
    // R11: switch to compare against stored 0x18 in the next cycle
    cfgRegEn = 1'b0; cfgFunc = 3'd2; opB = 16'h0018;
    #1 chk("R11 compare vs stored", 32'(result), 32'h1);
    opB = 16'h0019;
    #1 chk("R11 compare mismatch", 32'(result), 32'h0);
    cfgFunc = 3'd1; opB = 16'h0020;
    #1 chk("R11 subtract from stored", 32'(result), 32'hFFF8);

    // R9: stored carry at word top
    @(negedge clk);
    cfgFeedback = 1'b0; cfgFunc = 3'd0; opA = 16'hFFFF; opB = 16'h0001; cfgRegEn = 1'b1;
    @(negedge clk);
    cfgRegEn = 1'b0; cfgFunc = 3'd3; cfgUseReg = 1'b1;
    #1 chk("R9 stored wrap result", 32'(result), 32'h0);
    chk("R9 stored top carry", 32'(carryOut[15]), 32'h1);

    // R6: zero code ignores operands
    cfgUseReg = 1'b0; cfgFunc = 3'd6; opA = 16'h1234; opB = 16'h5678;
    #1 chk("R6 zero code", 32'(result), 32'h0);
    chk("R6 zero code carry", 32'(carryOut), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule